// File: doc/BRIEF.md
# Grouped Masked Event Interrupt Aggregator

This block collects a wide vector of hardware event inputs, split into three groups of 32, and turns them into one interrupt line per group for the processor. Each event input sets a sticky pending bit on its rising edge. A per-group enable word decides which pending bits may raise that group's line. Software reads the pending word, acknowledges events by writing ones to it, and changes an enable bit by read-modify-write of the whole enable word. All of this goes through a small 32-bit register port with read strobe, write strobe and byte address.

Global event number `n` belongs to group `n / 32`, at bit `n % 32`. For each group the block also presents a winner: a valid flag and a 5-bit index of the lowest-numbered bit that is both pending and enabled. An interrupt handler can use it to find the event to service without scanning the word.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset every pending word and every enable word reads 0, every `irq_line` bit is 0 and every `win_vld` bit is 0.
- R2: A 0-to-1 transition of `evt_in[32*g+b]` sets pending bit `b` of group `g` at the next clock. An input held high does not set the bit again after it has been cleared.
- R3: Pending word of group `g` sits at byte address `0x00 + 4*g` (0x00, 0x04, 0x08). Enable word of group `g` sits at `0x10 + 0x14*g` (0x10, 0x24, 0x38). A read with `bus_rd` high returns the full 32-bit word on `bus_rdata` in the same cycle.
- R4: A write to a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When a rising edge and a write-1 clear hit the same pending bit in the same cycle, the bit ends up set.
- R6: A write to an enable word replaces all 32 bits. An enable bit of 1 lets the matching pending bit take part in the group's interrupt and winner. An enable bit of 0 keeps it out.
- R7: `irq_line[g]` is a register holding the OR of (pending AND enable) of group `g` as it stood one clock earlier. Bit 0 is group 0 (CPU line 13), bit 1 is group 1 (line 11), bit 2 is group 2 (line 9).
- R8: `win_vld[g]` is 1 exactly when (pending AND enable) of group `g` is non-zero. `win_idx[5*g +: 5]` then holds the lowest set bit position of that value, and it holds 0 when `win_vld[g]` is 0.
- R9: A read of an unmapped address returns 0. `bus_rdata` is 0 whenever `bus_rd` is low. A write to an unmapped address changes no pending or enable word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 96 | Event inputs, bit 32*g+b is group g bit b |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_line | output | 3 | Registered interrupt line per group |
| win_vld | output | 3 | Winner present per group |
| win_idx | output | 15 | Winner bit index, 5 bits per group |

## Verification
A new rising edge on an event input and a software write-1 clear of the same pending bit can land in the same clock. The bench provokes this by driving the edge and the clearing write from the same falling edge. It then expects the bit to read back as set, while other bits cleared by the same write drop. A behavioural model also draws random edges and random writes every cycle, so both functions meet on many other bits, and the model's view of pending words, interrupt lines and winners is compared on every clock.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // byte offset of register g in a strided bank
  function automatic int bank_ofs(input int g, input int base, input int stride);
    return base + g * stride;
  endfunction

  // lowest set bit position of the low w bits, 0 if none
  function automatic int low_bit(input logic [63:0] v, input int w);
    int r;
    r = 0;
    for (int i = w - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/evt_group.sv
module evt_group #(
  parameter int GW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] evt,
  input  logic          st_we,
  input  logic          mk_we,
  input  logic [GW-1:0] wdata,
  output logic [GW-1:0] status,
  output logic [GW-1:0] mask,
  output logic          irq
);

  logic [GW-1:0] evt_q;
  logic [GW-1:0] rise;
  logic [GW-1:0] clr;
  logic [GW-1:0] st_q;
  logic [GW-1:0] mk_q;
  logic          irq_q;

  assign rise = evt & ~evt_q;
  assign clr  = st_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      st_q  <= '0;
      mk_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= evt;
      st_q  <= (st_q & ~clr) | rise;
      if (mk_we) mk_q <= wdata;
      irq_q <= |(st_q & mk_q);
    end
  end

  assign status = st_q;
  assign mask   = mk_q;
  assign irq    = irq_q;

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((status & $past(rise)) == $past(rise)));

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> ((status & $past(wdata & ~rise)) == '0));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((status & mask) != '0));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mk_we |=> (mask == $past(wdata)));

endmodule

// File: rtl/evt_low_enc.sv
module evt_low_enc #(
  parameter int GW = 32,
  parameter int IW = $clog2(GW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] sel,
  output logic          vld,
  output logic [IW-1:0] idx
);

  always_comb begin
    vld = |sel;
    idx = '0;
    for (int i = GW - 1; i >= 0; i--) begin
      if (sel[i]) idx = IW'(i);
    end
  end

  // R8
  win_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> sel[idx]);

  // R8
  win_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ((sel & ((GW'(1) << idx) - GW'(1))) == '0));

  // R8
  win_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> (idx == '0));

endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg #(
  parameter int NGRP      = 3,
  parameter int GW        = 32,
  parameter int AW        = 8,
  parameter int ST_BASE   = 0,
  parameter int ST_STRIDE = 4,
  parameter int MK_BASE   = 16,
  parameter int MK_STRIDE = 20,
  parameter int IW        = $clog2(GW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGRP*GW-1:0]   evt_in,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [GW-1:0]        bus_wdata,
  output logic [GW-1:0]        bus_rdata,
  output logic [NGRP-1:0]      irq_line,
  output logic [NGRP-1:0]      win_vld,
  output logic [NGRP*IW-1:0]   win_idx
);

  logic [GW-1:0]   st_w [NGRP];
  logic [GW-1:0]   mk_w [NGRP];
  logic [NGRP-1:0] st_sel;
  logic [NGRP-1:0] mk_sel;
  logic            map_hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign st_sel[g] = (bus_addr == AW'(evt_pkg::bank_ofs(g, ST_BASE, ST_STRIDE)));
    assign mk_sel[g] = (bus_addr == AW'(evt_pkg::bank_ofs(g, MK_BASE, MK_STRIDE)));

    evt_group #(.GW(GW)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_in[g*GW +: GW]),
      .st_we  (bus_wr && st_sel[g]),
      .mk_we  (bus_wr && mk_sel[g]),
      .wdata  (bus_wdata),
      .status (st_w[g]),
      .mask   (mk_w[g]),
      .irq    (irq_line[g])
    );

    evt_low_enc #(.GW(GW), .IW(IW)) u_enc (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (st_w[g] & mk_w[g]),
      .vld   (win_vld[g]),
      .idx   (win_idx[g*IW +: IW])
    );
  end

  assign map_hit = |{st_sel, mk_sel};

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      for (int g = 0; g < NGRP; g++) begin
        if (st_sel[g]) bus_rdata = bus_rdata | st_w[g];
        if (mk_sel[g]) bus_rdata = bus_rdata | mk_w[g];
      end
    end
  end

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !map_hit) |-> (bus_rdata == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_line == '0));

endmodule

// File: tb/sim_evt_irq_agg.sv
`timescale 1ns/1ps
module sim_evt_irq_agg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] evt_in = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_line;
  logic [2:0]  win_vld;
  logic [14:0] win_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_irq_agg u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_line(irq_line), .win_vld(win_vld), .win_idx(win_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit [31:0] m_pend [3];
  bit [31:0] m_en   [3];
  bit [95:0] m_last;
  bit [2:0]  m_irq;

  function automatic bit [31:0] m_read(input bit rd, input int a);
    bit [31:0] r;
    r = 0;
    if (rd) begin
      for (int k = 0; k < 3; k++) begin
        if (a == 4 * k) r = m_pend[k];
        if (a == 16 + 20 * k) r = m_en[k];
      end
    end
    return r;
  endfunction

  function automatic bit is_mapped(input int a);
    for (int k = 0; k < 3; k++)
      if (a == 4 * k || a == 16 + 20 * k) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    bit [2:0]  nxt_irq;
    bit [31:0] edges, wipe, act;
    int        lo;
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin m_pend[k] = 0; m_en[k] = 0; end
      m_last = 0;
      m_irq  = 0;
    end else begin
      for (int k = 0; k < 3; k++) nxt_irq[k] = ((m_pend[k] & m_en[k]) != 0);
      for (int k = 0; k < 3; k++) begin
        edges = evt_in[k*32 +: 32] & ~m_last[k*32 +: 32];
        wipe  = (bus_wr && bus_addr == 8'(4 * k)) ? bus_wdata : 32'h0;
        m_pend[k] = (m_pend[k] & ~wipe) | edges;
        if (bus_wr && bus_addr == 8'(16 + 20 * k)) m_en[k] = bus_wdata;
      end
      m_last = evt_in;
      m_irq  = nxt_irq;
    end
    #2;
    if (!done) begin
      chk("R7 irq_line", {29'd0, irq_line}, {29'd0, m_irq});
      for (int k = 0; k < 3; k++) begin
        act = m_pend[k] & m_en[k];
        lo = 0;
        for (int b = 31; b >= 0; b--) if (act[b]) lo = b;
        chk("R8 win_vld", {31'd0, win_vld[k]}, {31'd0, act != 0});
        chk("R8 win_idx", {27'd0, win_idx[k*5 +: 5]}, 32'(lo));
      end
      chk(is_mapped(bus_addr) ? "R3 rdata" : "R9 rdata", bus_rdata, m_read(bus_rd, bus_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; bus_addr = a;
    #1 chk(req, bus_rdata, e);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); evt_in[n] = 1'b1;
    @(negedge clk); evt_in[n] = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd_exp(8'h00, 32'h0, "R1 pend0");
    rd_exp(8'h38, 32'h0, "R1 en2");
    #1 chk("R1 irq", {29'd0, irq_line}, 32'h0);
    chk("R1 vld", {29'd0, win_vld}, 32'h0);
    // R6 / R3 enable words at their own addresses
    wr(8'h10, 32'h0000_00F0);
    rd_exp(8'h10, 32'h0000_00F0, "R6 en0");
    rd_exp(8'h24, 32'h0, "R3 en1 untouched");
    // R2 edges set pending bits
    pulse(4); pulse(6);
    idle(2);
    rd_exp(8'h00, 32'h0000_0050, "R2 pend0");
    #1 chk("R7 irq0", {31'd0, irq_line[0]}, 32'h1);
    chk("R8 idx0", {27'd0, win_idx[4:0]}, 32'd4);
    // R4 write-one clear
    wr(8'h00, 32'h0000_0010);
    rd_exp(8'h00, 32'h0000_0040, "R4 pend0");
    #1 chk("R8 idx0 after clear", {27'd0, win_idx[4:0]}, 32'd6);
    // R6 disabled events stay out
    pulse(64 + 31); pulse(64 + 2);
    idle(2);
    rd_exp(8'h08, 32'h8000_0004, "R2 pend2");
    #1 chk("R6 irq2 masked", {31'd0, irq_line[2]}, 32'h0);
    wr(8'h38, 32'h8000_0000);
    idle(2);
    #1 chk("R6 irq2 enabled", {31'd0, irq_line[2]}, 32'h1);
    chk("R8 idx2", {27'd0, win_idx[14:10]}, 32'd31);
    // R5 edge and clear in the same cycle
    @(negedge clk);
    evt_in[32 + 5] = 1'b1; evt_in[32 + 1] = 1'b1;
    @(negedge clk);
    evt_in[32 + 5] = 1'b0;
    @(negedge clk);
    evt_in[32 + 5] = 1'b1;
    bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'h0000_0022;
    @(negedge clk);
    bus_wr = 0;
    rd_exp(8'h04, 32'h0000_0020, "R5 pend1");
    // R2 held-high input does not re-set
    wr(8'h04, 32'h0000_0020);
    idle(2);
    rd_exp(8'h04, 32'h0, "R2 held high");
    evt_in[32 + 5] = 1'b0; evt_in[32 + 1] = 1'b0;
    // R9 unmapped access
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd_exp(8'h0C, 32'h0, "R9 unmapped read");
    rd_exp(8'h00, 32'h0000_0040, "R9 pend0 unchanged");
    rd_exp(8'h10, 32'h0000_00F0, "R9 en0 unchanged");
    @(negedge clk); bus_rd = 0; bus_addr = 8'h10;
    #1 chk("R9 no strobe", bus_rdata, 32'h0);
    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      evt_in = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      bus_wr = ($urandom % 3) == 0;
      bus_rd = ($urandom % 2) == 0;
      case ($urandom % 8)
        0: bus_addr = 8'h00; 1: bus_addr = 8'h04; 2: bus_addr = 8'h08;
        3: bus_addr = 8'h10; 4: bus_addr = 8'h24; 5: bus_addr = 8'h38;
        6: bus_addr = 8'h20; default: bus_addr = 8'($urandom);
      endcase
      bus_wdata = $urandom;
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; evt_in = '0;
    idle(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule